// File: doc/BRIEF.md
# Thirty-Two Line GPIO Bank with Edge Interrupts

This block controls 32 general-purpose pins through a small word-wide register bus. Software sets each line as an input or an output, picks open-drain operation per line, and writes output values. Software reads back a data view that mixes two sources. Lines set as outputs return the value last written. Lines set as inputs return the synchronised pad level, but only where the line's input buffer is enabled.

Every pad input passes through a two-flop synchroniser. Each line has an edge detector that fires on falling edges only, or on both edges. A detected edge is latched into a pending-event register. Software clears that register by writing ones. The pending events are ANDed with a mask and ORed into one interrupt line. An external interrupt controller handles priority and vectoring.

Register bit positions run opposite to line numbers: pin line n is held in register bit 31−n. The pad-side vectors (`pad_in`, `pad_oe`, `pad_out`, `pad_od`) are indexed by line number.

Top module: `gpio_bank`

## Requirements
- R1: After reset, every register reads 0, `pad_oe`, `pad_out` and `pad_od` are 0, and `irq` is 0.
- R2: Byte offsets are: direction 0x00, open-drain select 0x04, data 0x08, pending event 0x0C, interrupt mask 0x10, edge control 0x14, input enable 0x18. Direction, open-drain, mask, edge control and input enable read back the last value written. Any other offset reads 0, and writes to it change nothing.
- R3: Line n maps to register bit 31−n. `pad_out[n]` is data-shadow bit 31−n, `pad_od[n]` is open-drain bit 31−n, and `pad_in[n]` feeds bit 31−n.
- R4: Direction bit 1 makes the line an output (`pad_oe[n]` = 1). Direction bit 0 makes it an input.
- R5: A read of the data offset returns the following per bit:
  - for an output bit, the written shadow value, whatever the pad level;
  - for an input bit, the synchronised pad level when its input-enable bit is 1;
  - for an input bit, 0 when its input-enable bit is 0.
- R6: Edge-control bit 1 detects only falling edges (1 to 0) on that line. Bit 0 detects both edges. Detection works on the synchronised pad whatever the line's direction or input enable.
- R7: Writing 1 to a pending-event bit clears it. Writing 0 leaves it unchanged.
- R8: When a new edge and a clearing write hit the same bit in the same cycle, the bit ends set.
- R9: `irq` is 1 exactly when some bit is both pending and has mask bit 1. Events are latched even while masked.
- R10: A pad change set up before rising edge k shows in the data view after edge k+1 and in the pending-event register after edge k+2, and not earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Bus access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 5 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from `bus_addr` |
| pad_in | input | 32 | Pad input levels, indexed by line |
| pad_oe | output | 32 | Pad output enable, indexed by line |
| pad_out | output | 32 | Pad output value, indexed by line |
| pad_od | output | 32 | Pad open-drain select, indexed by line |
| irq | output | 1 | Combined masked interrupt |

## Verification
Several properties are checked on every cycle:
- every detected edge is pending in the next cycle, even against a clearing write;
- a cleared bit with no new edge drops;
- no event bit rises without an edge;
- register writes land, and the registers hold when there is no write;
- data reads never show a gated input;
- `irq` stays low while the mask is zero.

Other behaviour is shown only by the bench scenarios against its cycle model:
- the bit-reversed pad mapping;
- falling-only versus both-edge selection;
- the exact two- and three-edge latency;
- shadow readback of outputs when the pad disagrees;
- ignored writes to unmapped offsets.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;
  localparam int ADDR_W = 5;

  typedef enum logic [ADDR_W-1:0] {
    OFS_DIR = 5'h00,
    OFS_ODS = 5'h04,
    OFS_DAT = 5'h08,
    OFS_EVT = 5'h0C,
    OFS_MSK = 5'h10,
    OFS_EDG = 5'h14,
    OFS_IBE = 5'h18
  } reg_ofs_e;
endpackage

// File: rtl/gpio_bank_sync.sv
module gpio_bank_sync #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_in,
  output logic [W-1:0] d_out
);
  logic [W-1:0] s1_q, s2_q, s1_d, s2_d;

  always_comb begin
    s1_d = d_in;
    s2_d = s1_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= s1_d;
      s2_q <= s2_d;
    end
  end

  assign d_out = s2_q;
endmodule

// File: rtl/gpio_bank_evt.sv
module gpio_bank_evt #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] cur_i,
  input  logic [W-1:0] fall_only_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] evt_o
);
  logic [W-1:0] prev_q, prev_d;
  logic [W-1:0] evt_q, evt_d;
  logic [W-1:0] edge_v;

  always_comb begin
    prev_d = cur_i;
    // falling edges always count; rising edges only in both-edge mode
    edge_v = (prev_q & ~cur_i) | (~fall_only_i & ~prev_q & cur_i);
    // new edge overrides a simultaneous clear
    evt_d  = (evt_q & ~clr_i) | edge_v;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= '0;
      evt_q  <= '0;
    end else begin
      prev_q <= prev_d;
      evt_q  <= evt_d;
    end
  end

  assign evt_o = evt_q;

  assert_edge_sets_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (|edge_v) |=> ((evt_q & $past(edge_v)) == $past(edge_v)));

  assert_w1c_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (|(clr_i & ~edge_v)) |=> ((evt_q & $past(clr_i & ~edge_v)) == '0));

  assert_no_spurious_R6: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((evt_q & ~$past(evt_q) & ~$past(edge_v)) == '0));
endmodule

// File: rtl/gpio_bank_regs.sv
module gpio_bank_regs
  import gpio_bank_pkg::*;
#(
  parameter int W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel_i,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [W-1:0]      wdata_i,
  output logic [W-1:0]      rdata_o,
  input  logic [W-1:0]      cur_i,
  input  logic [W-1:0]      evt_i,
  output logic [W-1:0]      dir_o,
  output logic [W-1:0]      ods_o,
  output logic [W-1:0]      dat_o,
  output logic [W-1:0]      msk_o,
  output logic [W-1:0]      edg_o,
  output logic [W-1:0]      ibe_o,
  output logic [W-1:0]      clr_o
);
  logic         wr_any;
  logic         we_dir, we_ods, we_dat, we_msk, we_edg, we_ibe, we_evt;
  logic [W-1:0] dir_q, ods_q, dat_q, msk_q, edg_q, ibe_q;
  logic [W-1:0] dir_d, ods_d, dat_d, msk_d, edg_d, ibe_d;
  logic [W-1:0] dat_view;

  always_comb begin
    wr_any = sel_i & wr_i;
    we_dir = wr_any & (addr_i == OFS_DIR);
    we_ods = wr_any & (addr_i == OFS_ODS);
    we_dat = wr_any & (addr_i == OFS_DAT);
    we_evt = wr_any & (addr_i == OFS_EVT);
    we_msk = wr_any & (addr_i == OFS_MSK);
    we_edg = wr_any & (addr_i == OFS_EDG);
    we_ibe = wr_any & (addr_i == OFS_IBE);
  end

  always_comb begin
    dir_d = dir_q;
    ods_d = ods_q;
    dat_d = dat_q;
    msk_d = msk_q;
    edg_d = edg_q;
    ibe_d = ibe_q;
    if (we_dir) dir_d = wdata_i;
    if (we_ods) ods_d = wdata_i;
    if (we_dat) dat_d = wdata_i;
    if (we_msk) msk_d = wdata_i;
    if (we_edg) edg_d = wdata_i;
    if (we_ibe) ibe_d = wdata_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q <= '0;
      ods_q <= '0;
      dat_q <= '0;
      msk_q <= '0;
      edg_q <= '0;
      ibe_q <= '0;
    end else begin
      dir_q <= dir_d;
      ods_q <= ods_d;
      dat_q <= dat_d;
      msk_q <= msk_d;
      edg_q <= edg_d;
      ibe_q <= ibe_d;
    end
  end

  always_comb begin
    clr_o    = we_evt ? wdata_i : '0;
    dat_view = (dir_q & dat_q) | (~dir_q & ibe_q & cur_i);
    unique case (addr_i)
      OFS_DIR: rdata_o = dir_q;
      OFS_ODS: rdata_o = ods_q;
      OFS_DAT: rdata_o = dat_view;
      OFS_EVT: rdata_o = evt_i;
      OFS_MSK: rdata_o = msk_q;
      OFS_EDG: rdata_o = edg_q;
      OFS_IBE: rdata_o = ibe_q;
      default: rdata_o = '0;
    endcase
  end

  assign dir_o = dir_q;
  assign ods_o = ods_q;
  assign dat_o = dat_q;
  assign msk_o = msk_q;
  assign edg_o = edg_q;
  assign ibe_o = ibe_q;

  assert_dir_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    we_dir |=> (dir_q == $past(wdata_i)));

  assert_hold_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_any |=> $stable({dir_q, ods_q, dat_q, msk_q, edg_q, ibe_q}));

  assert_input_gated_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_i == OFS_DAT) |-> ((rdata_o & ~dir_q & ~ibe_q) == '0));
endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
  import gpio_bank_pkg::*;
#(
  parameter int NLINES = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [NLINES-1:0] bus_wdata,
  output logic [NLINES-1:0] bus_rdata,
  input  logic [NLINES-1:0] pad_in,
  output logic [NLINES-1:0] pad_oe,
  output logic [NLINES-1:0] pad_out,
  output logic [NLINES-1:0] pad_od,
  output logic              irq
);
  localparam int TOP = NLINES - 1;

  logic [NLINES-1:0] pin_bits, cur_bits;
  logic [NLINES-1:0] dir_q, ods_q, dat_q, msk_q, edg_q, ibe_q, evt_q, clr_v;

  // line n <-> register bit TOP-n
  for (genvar n = 0; n < NLINES; n++) begin : g_line
    assign pin_bits[TOP-n] = pad_in[n];
    assign pad_oe[n]       = dir_q[TOP-n];
    assign pad_out[n]      = dat_q[TOP-n];
    assign pad_od[n]       = ods_q[TOP-n];
  end

  gpio_bank_sync #(.W(NLINES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_in  (pin_bits),
    .d_out (cur_bits)
  );

  gpio_bank_evt #(.W(NLINES)) u_evt (
    .clk         (clk),
    .rst_n       (rst_n),
    .cur_i       (cur_bits),
    .fall_only_i (edg_q),
    .clr_i       (clr_v),
    .evt_o       (evt_q)
  );

  gpio_bank_regs #(.W(NLINES)) u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .sel_i   (bus_sel),
    .wr_i    (bus_wr),
    .addr_i  (bus_addr),
    .wdata_i (bus_wdata),
    .rdata_o (bus_rdata),
    .cur_i   (cur_bits),
    .evt_i   (evt_q),
    .dir_o   (dir_q),
    .ods_o   (ods_q),
    .dat_o   (dat_q),
    .msk_o   (msk_q),
    .edg_o   (edg_q),
    .ibe_o   (ibe_q),
    .clr_o   (clr_v)
  );

  assign irq = |(evt_q & msk_q);

  assert_irq_masked_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (msk_q == '0) |-> !irq);

  assert_irq_needs_evt_R9: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (evt_q != '0));
endmodule

// File: tb/gpio_bank_tb.sv
`timescale 1ns/100ps
module gpio_bank_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0, bus_wr = 1'b0;
  logic [4:0]  bus_addr = 5'h0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [31:0] pad_in = '0;
  logic [31:0] pad_oe, pad_out, pad_od;
  logic        irq;

  int n_cmp = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  gpio_bank u_dut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pad_in(pad_in), .pad_oe(pad_oe), .pad_out(pad_out), .pad_od(pad_od),
    .irq(irq)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  logic [31:0] m_dir, m_ods, m_dat, m_evt, m_msk, m_edg, m_ibe;
  logic [31:0] hist[$];

  function automatic logic [31:0] rev(logic [31:0] v);
    logic [31:0] r;
    for (int i = 0; i < 32; i++) r[31-i] = v[i];
    return r;
  endfunction

  function automatic logic [31:0] mread(logic [4:0] a);
    case (a)
      5'h00: return m_dir;
      5'h04: return m_ods;
      5'h08: return (m_dir & m_dat) | (~m_dir & m_ibe & rev(hist[1]));
      5'h0C: return m_evt;
      5'h10: return m_msk;
      5'h14: return m_edg;
      5'h18: return m_ibe;
      default: return 32'h0;
    endcase
  endfunction

  function automatic string rtag(logic [4:0] a);
    if (a == 5'h08) return "R5 data view";
    if (a == 5'h0C) return "R7 event reg";
    return "R2 register read";
  endfunction

  always @(posedge clk) begin
    logic [31:0] cur, prv, edg, clr;
    if (!rst_n) begin
      {m_dir, m_ods, m_dat, m_evt, m_msk, m_edg, m_ibe} = '0;
      hist = {32'h0, 32'h0, 32'h0};
    end else begin
      cur = rev(hist[1]);
      prv = rev(hist[2]);
      edg = (prv & ~cur) | (~m_edg & ~prv & cur);
      clr = (bus_sel && bus_wr && bus_addr == 5'h0C) ? bus_wdata : 32'h0;
      if (bus_sel && bus_wr) begin
        case (bus_addr)
          5'h00: m_dir = bus_wdata;
          5'h04: m_ods = bus_wdata;
          5'h08: m_dat = bus_wdata;
          5'h10: m_msk = bus_wdata;
          5'h14: m_edg = bus_wdata;
          5'h18: m_ibe = bus_wdata;
          default: ;
        endcase
      end
      m_evt = (m_evt & ~clr) | edg;
      hist.push_front(pad_in);
      void'(hist.pop_back());
    end
    #1;
    chk(rtag(bus_addr), bus_rdata, mread(bus_addr));
    chk("R4 pad_oe", pad_oe, rev(m_dir));
    chk("R3 pad_out", pad_out, rev(m_dat));
    chk("R3 pad_od", pad_od, rev(m_ods));
    chk("R9 irq", {31'b0, irq}, {31'b0, |(m_evt & m_msk)});
  end

  // ---------------- stimulus helpers ----------------
  task automatic wr(logic [4:0] a, logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd(logic [4:0] a, output logic [31:0] v);
    @(negedge clk);
    bus_addr = a;
    #1 v = bus_rdata;
  endtask

  task automatic rd_chk(string tag, logic [4:0] a, logic [31:0] exp);
    logic [31:0] v;
    rd(a, v);
    chk(tag, v, exp);
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  // drive pad, check event reg is still clear after edge k+1, then check after k+2
  task automatic edge_probe(logic [31:0] newpad, logic [31:0] exp, string tag, bit clear);
    @(negedge clk);
    pad_in = newpad;
    bus_addr = 5'h0C;
    @(negedge clk);
    @(negedge clk);
    #1 chk("R10 event not before third edge", bus_rdata, 32'h0);
    @(negedge clk);
    #1 chk(tag, bus_rdata, exp);
    if (clear) wr(5'h0C, 32'hFFFF_FFFF);
  endtask

  // ---------------- watchdog ----------------
  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL R1 watchdog actual=timeout expected=completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  // ---------------- scenario ----------------
  initial begin
    idle(3);
    rst_n = 1'b1;

    // R1: reset state
    for (int a = 0; a <= 24; a += 4) rd_chk("R1 reset value", 5'(a), 32'h0);
    chk("R1 pad_oe reset", pad_oe, 32'h0);
    chk("R1 irq reset", {31'b0, irq}, 32'h0);

    // R2: readback and unmapped offset
    wr(5'h04, 32'hA5A5_0F0F); rd_chk("R2 open-drain readback", 5'h04, 32'hA5A5_0F0F);
    wr(5'h10, 32'h1234_5678); rd_chk("R2 mask readback", 5'h10, 32'h1234_5678);
    wr(5'h10, 32'h0);
    wr(5'h14, 32'hFFFF_0000); rd_chk("R2 edge ctrl readback", 5'h14, 32'hFFFF_0000);
    wr(5'h14, 32'h0);
    wr(5'h18, 32'h0F0F_F0F0); rd_chk("R2 input enable readback", 5'h18, 32'h0F0F_F0F0);
    wr(5'h18, 32'h0);
    wr(5'h1C, 32'hFFFF_FFFF);
    rd_chk("R2 unmapped reads zero", 5'h1C, 32'h0);
    rd_chk("R2 unmapped write ignored", 5'h04, 32'hA5A5_0F0F);
    wr(5'h04, 32'h0);

    // R3 / R4: reversed mapping and direction
    wr(5'h00, 32'h0000_000F);
    chk("R4 output enable lines 28..31", pad_oe, 32'hF000_0000);
    wr(5'h08, 32'h0000_0005);
    chk("R3 pad_out reversed", pad_out, 32'hA000_0000);
    wr(5'h04, 32'h0000_0001);
    chk("R3 pad_od reversed", pad_od, 32'h8000_0000);
    wr(5'h04, 32'h0);

    // R5: data view
    @(negedge clk); pad_in = 32'h0000_0001;
    idle(3);
    rd_chk("R5 input gated off", 5'h08, 32'h0000_0005);
    wr(5'h18, 32'hFFFF_FFFF);
    rd_chk("R5 input enabled, line 0 at bit 31", 5'h08, 32'h8000_0005);
    @(negedge clk); pad_in = 32'hF000_0001;
    idle(3);
    rd_chk("R5 outputs read shadow not pad", 5'h08, 32'h8000_0005);
    @(negedge clk); pad_in = 32'h0;
    idle(3);
    rd_chk("R5 input low", 5'h08, 32'h0000_0005);
    wr(5'h0C, 32'hFFFF_FFFF);
    rd_chk("R7 all events cleared", 5'h0C, 32'h0);

    // R6 / R10: edge selection on line 5 (bit 26)
    edge_probe(32'h0000_0020, 32'h0400_0000, "R6 both-edge rise", 1'b1);
    edge_probe(32'h0000_0000, 32'h0400_0000, "R6 both-edge fall", 1'b1);
    wr(5'h14, 32'h0400_0000);
    edge_probe(32'h0000_0020, 32'h0000_0000, "R6 falling-only ignores rise", 1'b1);
    edge_probe(32'h0000_0000, 32'h0400_0000, "R6 falling-only fall", 1'b1);
    wr(5'h14, 32'h0);

    // R9: masking, latch while masked
    edge_probe(32'h0000_0020, 32'h0400_0000, "R9 event latched while masked", 1'b0);
    chk("R9 irq low while masked", {31'b0, irq}, 32'h0);
    wr(5'h10, 32'h0000_0001);
    chk("R9 other mask bit no irq", {31'b0, irq}, 32'h0);
    wr(5'h10, 32'h0400_0000);
    chk("R9 irq on unmask", {31'b0, irq}, 32'h1);

    // R7: write-one-to-clear
    wr(5'h0C, 32'hFBFF_FFFF);
    rd_chk("R7 zero bit leaves event", 5'h0C, 32'h0400_0000);
    chk("R7 irq held", {31'b0, irq}, 32'h1);
    wr(5'h0C, 32'h0400_0000);
    rd_chk("R7 one bit clears event", 5'h0C, 32'h0);
    chk("R9 irq drops after clear", {31'b0, irq}, 32'h0);

    // R8: edge and clear in the same cycle
    @(negedge clk); pad_in = 32'h0;
    @(negedge clk);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 5'h0C; bus_wdata = 32'h0400_0000;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
    #1 chk("R8 edge wins over clear", bus_rdata, 32'h0400_0000);
    chk("R8 irq from surviving event", {31'b0, irq}, 32'h1);
    wr(5'h0C, 32'hFFFF_FFFF);

    // R1: reset in mid-run
    wr(5'h00, 32'hFFFF_FFFF);
    @(negedge clk); rst_n = 1'b0;
    #1 chk("R1 pad_oe after reset", pad_oe, 32'h0);
    idle(2);
    rst_n = 1'b1;
    rd_chk("R1 direction after reset", 5'h00, 32'h0);
    rd_chk("R1 mask after reset", 5'h10, 32'h0);
    idle(4);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule